// File: doc/BRIEF.md
# Timer Update-Event and Preload Controller

This block is a 16-bit up-counting timer core with a programmable clock divider. Software sets the wrap limit, the divider ratio and one compare value by writing preload registers. Each preload register has a working (shadow) copy that the timer actually uses. A shadow copy is refreshed only when an update event occurs. An update event is raised by a counter wrap, by a software update pulse, or by a reset pulse from an external slave controller. A control bit can suppress update events. While that bit is set, the software pulse and the slave reset still restart the counter and the divider, but every shadow value stays as it is.

A small output-mode field can be buffered in the same way. It can take effect as soon as it is written, or only when software issues a commutation pulse. Optionally, a rising edge on the trigger input can also make it take effect. The block keeps a sticky update flag and produces a one-cycle DMA request. Software chooses whether that request follows compare matches or update events. A separate hardware start input can set the run bit.

Top module: `tim_upd_ctl`

## Requirements
- R1: After reset, the control register reads 0, the counter is 0, the update flag is 0, the mode output is 0, the DMA request is 0, and the wrap-limit shadow reads 0xFFFF.
- R2: The control register (address 0) uses bits 0 run, 1 update-off, 2 mode-buffered, 3 trigger-latch-select and 4 DMA-on-update; all its other bits read 0. The event register (address 1) is write-only: bit 0 is the update pulse, bit 1 is the commutation pulse, and it always reads 0.
- R3: The counter advances only while the run bit is 1. It advances once every (divider shadow + 1) clocks, counts from 0 up to the wrap-limit shadow, and then returns to 0.
- R4: With update-off clear, a counter wrap or an update pulse loads the wrap-limit, divider and compare shadows (read at addresses 8, 9, 10) from their preloads (addresses 3, 4, 5) and sets the update flag.
- R5: With update-off set, no wrap, update pulse or slave reset changes any shadow value, and none of them sets the update flag.
- R6: An update pulse or a slave reset clears the counter and the divider on the same clock edge, whatever the state of update-off.
- R7: A one-cycle pulse on trig_start sets the run bit.
- R8: The update flag (address 2, bit 0) stays set until software writes 0 to that bit. Writing 1 to it has no effect.
- R9: With mode-buffered clear, a write to the mode preload (address 6) appears on cc_mode one clock later.
- R10: With mode-buffered set and trigger-latch-select clear, cc_mode takes the mode preload only on a commutation pulse. Trigger edges are ignored.
- R11: With mode-buffered and trigger-latch-select both set, a rising edge on trig_in also makes cc_mode take the mode preload.
- R12: dma_req is a one-cycle pulse. With DMA-on-update clear, it is raised in the cycle in which the counter reaches the compare shadow. With DMA-on-update set, it is raised in the cycle after each update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| trig_start | input | 1 | Hardware start pulse; sets the run bit |
| trig_in | input | 1 | Trigger input; its rising edge can latch the mode |
| slave_rst | input | 1 | Slave-controller reset pulse |
| count | output | 16 | Current counter value |
| cc_mode | output | 4 | Active output-mode field |
| upd_flag | output | 1 | Sticky update flag |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
The hardest case is an update pulse or slave reset issued while update-off is set. A design that couples the counter restart to the shadow load would either skip the restart or quietly reload the wrap limit. The bench watches the counter and reads back the shadows and the flag to catch both faults. It also samples the counter on every cycle after a restart with a divide-by-two setting, which exposes an off-by-one in the divider or the wrap. It times each DMA pulse against the compare point and the wrap point for both source settings. It drives trigger edges with trigger latching off to prove they change nothing, then with it on to prove they latch.

// File: rtl/tim_upd_ctl.sv
module tim_upd_ctl #(
  parameter int W = 16,
  parameter int MW = 4,
  parameter logic [W-1:0] ARR_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          trig_start,
  input  logic          trig_in,
  input  logic          slave_rst,
  output logic [W-1:0]  count,
  output logic [MW-1:0] cc_mode,
  output logic          upd_flag,
  output logic          dma_req
);
  localparam logic [3:0] A_CTL = 4'd0, A_EVT = 4'd1, A_STS = 4'd2, A_ARR = 4'd3,
                         A_PSC = 4'd4, A_CMP = 4'd5, A_MOD = 4'd6, A_CNT = 4'd7,
                         A_ARS = 4'd8, A_PSS = 4'd9, A_CMS = 4'd10;
  localparam logic [W-1:0] ONE = 1;

  logic run, upd_off, cc_pre, cc_tsel, dma_sel, trig_q;
  logic [W-1:0] arr_pre, psc_pre, cmp_pre, arr_sh, psc_sh, cmp_sh, pc;
  logic [MW-1:0] mode_pre;

  wire wr_ctl  = wr_en && addr == A_CTL;
  wire ug      = wr_en && addr == A_EVT && wdata[0];
  wire comg    = wr_en && addr == A_EVT && wdata[1];
  wire reinit  = ug || slave_rst;
  wire tick    = pc == psc_sh;
  wire step    = run && !reinit && tick;
  wire ovf     = step && count == arr_sh;
  wire [W-1:0] cnt_nx = ovf ? '0 : count + ONE;
  wire uev     = !upd_off && (ovf || reinit);
  wire cmp_hit = step && cnt_nx == cmp_sh;
  wire trig_rise = trig_in && !trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {dma_sel, cc_tsel, cc_pre, upd_off, run} <= '0;
      arr_pre <= ARR_RST; psc_pre <= '0; cmp_pre <= '0; mode_pre <= '0;
      arr_sh <= ARR_RST; psc_sh <= '0; cmp_sh <= '0;
      pc <= '0; count <= '0; upd_flag <= 1'b0; dma_req <= 1'b0;
      trig_q <= 1'b0; cc_mode <= '0;
    end else begin
      if (wr_ctl) {dma_sel, cc_tsel, cc_pre, upd_off, run} <= wdata[4:0];
      if (trig_start) run <= 1'b1;
      if (wr_en && addr == A_ARR) arr_pre <= wdata;
      if (wr_en && addr == A_PSC) psc_pre <= wdata;
      if (wr_en && addr == A_CMP) cmp_pre <= wdata;
      if (wr_en && addr == A_MOD) mode_pre <= wdata[MW-1:0];
      if (uev) begin
        arr_sh <= arr_pre; psc_sh <= psc_pre; cmp_sh <= cmp_pre;
      end
      if (reinit) pc <= '0;
      else if (run) pc <= tick ? '0 : pc + ONE;
      if (reinit) count <= '0;
      else if (step) count <= cnt_nx;
      if (uev) upd_flag <= 1'b1;
      else if (wr_en && addr == A_STS && !wdata[0]) upd_flag <= 1'b0;
      dma_req <= dma_sel ? uev : cmp_hit;
      trig_q <= trig_in;
      if (!cc_pre) begin
        if (wr_en && addr == A_MOD) cc_mode <= wdata[MW-1:0];
      end else if (comg || (cc_tsel && trig_rise)) begin
        cc_mode <= mode_pre;
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTL:   rdata = {{(W-5){1'b0}}, dma_sel, cc_tsel, cc_pre, upd_off, run};
      A_STS:   rdata = {{(W-1){1'b0}}, upd_flag};
      A_ARR:   rdata = arr_pre;
      A_PSC:   rdata = psc_pre;
      A_CMP:   rdata = cmp_pre;
      A_MOD:   rdata = {{(W-MW){1'b0}}, mode_pre};
      A_CNT:   rdata = count;
      A_ARS:   rdata = arr_sh;
      A_PSS:   rdata = psc_sh;
      A_CMS:   rdata = cmp_sh;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/tim_upd_ctl_chk.sv
module tim_upd_ctl_chk #(
  parameter int W = 16,
  parameter int MW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          upd_off,
  input logic          uev,
  input logic          reinit,
  input logic          cc_pre,
  input logic          cc_tsel,
  input logic          comg,
  input logic          trig_rise,
  input logic [W-1:0]  arr_sh,
  input logic [W-1:0]  psc_sh,
  input logic [W-1:0]  cmp_sh,
  input logic [W-1:0]  count,
  input logic [MW-1:0] cc_mode,
  input logic          upd_flag,
  input logic [3:0]    addr,
  input logic [W-1:0]  rdata
);
  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    upd_off |=> $stable(arr_sh) && $stable(psc_sh) && $stable(cmp_sh));
  a_r5_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    upd_off && !upd_flag |=> !upd_flag);
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    uev |=> upd_flag);
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> count == '0);
  a_r3_halted: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !reinit |=> $stable(count));
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cc_pre && !comg && !(cc_tsel && trig_rise) |=> $stable(cc_mode));
  a_r2_ctl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 4'd0 |-> rdata[W-1:5] == '0);
  a_r2_evt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 4'd1 |-> rdata == '0);
endmodule

bind tim_upd_ctl tim_upd_ctl_chk #(.W(W), .MW(MW)) chk (
  .clk(clk), .rst_n(rst_n), .run(run), .upd_off(upd_off), .uev(uev),
  .reinit(reinit), .cc_pre(cc_pre), .cc_tsel(cc_tsel), .comg(comg),
  .trig_rise(trig_rise), .arr_sh(arr_sh), .psc_sh(psc_sh), .cmp_sh(cmp_sh),
  .count(count), .cc_mode(cc_mode), .upd_flag(upd_flag), .addr(addr),
  .rdata(rdata)
);

// File: tb/tim_upd_ctl_test.sv
module tim_upd_ctl_test;
  logic clk = 0, rst_n = 0, wr_en = 0, trig_start = 0, trig_in = 0, slave_rst = 0;
  logic [3:0] addr = 0;
  logic [15:0] wdata = 0, rdata, count;
  logic [3:0] cc_mode;
  logic upd_flag, dma_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tim_upd_ctl uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .trig_start(trig_start), .trig_in(trig_in), .slave_rst(slave_rst),
    .count(count), .cc_mode(cc_mode), .upd_flag(upd_flag), .dma_req(dma_req));

  // {write addr, write data, read addr, expected read}
  localparam logic [39:0] VEC [6] = '{
    {4'd0, 16'hFFE2, 4'd0, 16'h0002},
    {4'd1, 16'h0001, 4'd1, 16'h0000},
    {4'd3, 16'h1234, 4'd3, 16'h1234},
    {4'd4, 16'h0005, 4'd4, 16'h0005},
    {4'd5, 16'h0AAA, 4'd5, 16'h0AAA},
    {4'd6, 16'h000C, 4'd8, 16'hFFFF}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, string tag, logic [15:0] exp);
    addr = a; #1; check(tag, rdata, exp);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1;
    repeat (2) @(negedge clk);
    trig_in = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, "R1 ctrl", 0);
    check("R1 count", count, 0);
    check("R1 flag", upd_flag, 0);
    check("R1 mode", cc_mode, 0);
    check("R1 dma", dma_req, 0);
    rd(8, "R1 arr shadow", 16'hFFFF);

    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][39:36], VEC[i][35:20]);
      rd(VEC[i][19:16], $sformatf("R2,R5 vector %0d", i), VEC[i][15:0]);
    end
    check("R9 immediate mode", cc_mode, 4'hC);
    rd(9, "R5 psc shadow", 0);
    rd(10, "R5 cmp shadow", 0);
    rd(2, "R5 flag", 0);

    wr(0, 3);
    repeat (5) @(negedge clk);
    wr(1, 1);
    check("R6 update pulse restart with updates off", count, 0);
    rd(8, "R5 arr shadow after pulse", 16'hFFFF);
    repeat (4) @(negedge clk);
    slave_rst = 1; @(negedge clk); slave_rst = 0;
    check("R6 slave reset restart", count, 0);
    rd(2, "R5 flag after slave reset", 0);

    wr(0, 1);
    wr(1, 1);
    check("R6 restart with updates on", count, 0);
    rd(8, "R4 arr load", 16'h1234);
    rd(9, "R4 psc load", 16'h0005);
    rd(10, "R4 cmp load", 16'h0AAA);
    rd(2, "R4 flag", 1);

    wr(2, 1);
    rd(2, "R8 write one keeps flag", 1);
    wr(2, 0);
    rd(2, "R8 write zero clears", 0);

    wr(3, 3); wr(4, 1); wr(1, 1);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check($sformatf("R3 divided count k=%0d", k), count, (k / 2) % 4);
    end
    wr(3, 2);
    wr(2, 0);
    repeat (10) @(negedge clk);
    rd(2, "R4 flag on wrap", 1);
    rd(8, "R4 arr reload on wrap", 2);

    wr(0, 0);
    held = count;
    repeat (5) @(negedge clk);
    check("R3 halted", count, held);

    @(negedge clk); trig_start = 1; @(negedge clk); trig_start = 0;
    rd(0, "R7 hardware start", 1);

    wr(3, 3); wr(5, 2); wr(0, 1); wr(1, 1);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      check($sformatf("R12 compare dma k=%0d", k), dma_req, (k == 4 || k == 12));
    end
    wr(0, 16'h11);
    wr(1, 1);
    check("R12 dma on update pulse", dma_req, 1);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      check($sformatf("R12 update dma k=%0d", k), dma_req, (k == 8 || k == 16));
    end

    wr(0, 0);
    wr(6, 5);
    check("R9 mode follows write", cc_mode, 5);
    wr(0, 4);
    wr(6, 9);
    check("R10 buffered mode held", cc_mode, 5);
    pulse_trig();
    check("R10 trigger ignored", cc_mode, 5);
    wr(1, 2);
    check("R10 commutation latches", cc_mode, 9);
    wr(0, 12);
    wr(6, 3);
    check("R11 held before trigger", cc_mode, 9);
    pulse_trig();
    check("R11 trigger latches", cc_mode, 3);

    wr(0, 3);
    wr(3, 7);
    wr(2, 0);
    repeat (20) @(negedge clk);
    rd(2, "R5 no flag on wrap", 0);
    rd(8, "R5 arr kept on wrap", 3);

    finish_run();
  end
endmodule